// File: doc/BRIEF.md
# Multi-Bank Ratio Clock Divider with Coincidence Marker

This block takes one fast internal clock and produces four kinds of divided clock outputs. Bank A, bank B and bank C each have several outputs, and there is one feedback output. Each group has its own 2-bit ratio select. A coincidence marker (`sync_n`) goes low for one period of the faster of bank A and bank C. That low period ends on the cycle just before the rising edges of those two banks line up. The block sits behind an external frequency synthesizer. Tri-state pads are represented by the `out_en` flag.

A small controller sequences the dividers. It has three states. ST_OFF is held while `rst_n` is low and for the first clock after release; the selects are sampled on every clock in this state. ST_RUN means the dividers are counting with the selects in force. ST_PEND means a different select value has been requested and is waiting for an alignment point. The transitions are:
- OFF→RUN on the first clock after reset release.
- RUN→PEND when the requested selects differ from the ones in force and this cycle is not an alignment point.
- PEND→RUN at the next alignment point, where the new selects load, or when the request goes back to the value in force.
- Any state→OFF at once when `rst_n` goes low.

An alignment point is a cycle in which every divider counter, including the marker's own counter, sits on its last count.

Per-output freeze controls park chosen outputs low without runt pulses. A control input inverts the upper half of bank C.

Top module: `mbdiv_top`

## Requirements
- R1: Bank A divides by 4, 6, 8 or 12 for `sel_a` = 0, 1, 2, 3. Each output is high for the first half of its count and low for the second half (50% duty).
- R2: Bank B divides by 4, 6, 8 or 10 for `sel_b` = 0..3, with 50% duty.
- R3: Bank C divides by 2, 4, 6 or 8 for `sel_c` = 0..3, with 50% duty.
- R4: `qfb` divides by 4, 6, 8 or 10 for `sel_fb` = 0..3. Setting `fb_x2` = 1 doubles this to 8, 12, 16 or 20.
- R5: On the first clock edge after reset release, every divided output rises together. Output t cycles later follows t modulo its own divide value.
- R6: Let L be the least common multiple of the bank A and bank C divides, and m the smaller of the two. `sync_n` is low exactly when (t mod L) ≥ L−m, and high otherwise.
- R7: With `inv_c` = 1, bank C outputs with index ≥ NC/2 (qc[2] and qc[3] by default) are inverted. The lower bank C outputs are never inverted.
- R8: While `rst_n` is low, which acts asynchronously, all outputs including `sync_n` are low and `out_en` is low. `out_en` is high from the first edge after release.
- R9: A select change made while running takes effect only on the cycle after the next alignment point. From that cycle all counters restart from zero.
- R10: `frz` bits [NA-1:0] freeze qa, [NA+NB-1:NA] freeze qb, the next NC-1 bits freeze qc[1..NC-1], and the top bit freezes `sync_n`. A frozen output is held low. A freeze or unfreeze request is taken only on an edge where that output is low, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous master reset, active low; also the output enable |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 2 | Feedback ratio select |
| fb_x2 | input | 1 | Extra divide-by-2 on the feedback output |
| inv_c | input | 1 | Invert the upper half of bank C |
| frz | input | NA+NB+NC | Per-output freeze requests |
| qa | output | NA | Bank A outputs |
| qb | output | NB | Bank B outputs |
| qc | output | NC | Bank C outputs |
| qfb | output | 1 | Feedback output |
| sync_n | output | 1 | Coincidence marker, active low |
| out_en | output | 1 | Output drivers enabled |

## Verification
The hardest case to reach from the ports is a select change landing in the middle of a frame, because the old ratio must survive until the full common period closes. The bench starts bank A at divide-by-8 while the other banks run fast, so the frame is 8 cycles long. It then requests divide-by-4 two cycles in and samples cycles that would show high only if the change had been applied early. Freeze requests are likewise raised while the target output is high. The bench then checks that the pulse in progress completes and that the pulse after the release is a whole one.

// File: rtl/mbdiv_pkg.sv
package mbdiv_pkg;

    localparam int CW = 5;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } mode_e;

    typedef struct packed {
        logic [1:0] a;
        logic [1:0] b;
        logic [1:0] c;
        logic [1:0] f;
        logic       x2;
    } cfg_t;

    function automatic cnt_t div_a(input logic [1:0] s);
        case (s)
            2'd0:    return cnt_t'(4);
            2'd1:    return cnt_t'(6);
            2'd2:    return cnt_t'(8);
            default: return cnt_t'(12);
        endcase
    endfunction

    function automatic cnt_t div_b(input logic [1:0] s);
        return cnt_t'(4 + 2 * int'(s));
    endfunction

    function automatic cnt_t div_c(input logic [1:0] s);
        return cnt_t'(2 + 2 * int'(s));
    endfunction

    function automatic cnt_t div_f(input logic [1:0] s, input logic x2);
        int base;
        base = 4 + 2 * int'(s);
        return x2 ? cnt_t'(base * 2) : cnt_t'(base);
    endfunction

    // smallest common multiple; y is at most 8, so at most 8 candidates
    function automatic cnt_t lcm2(input cnt_t x, input cnt_t y);
        cnt_t r;
        r = x;
        for (int i = 8; i >= 1; i--) begin
            if (y != '0) begin
                if (((int'(x) * i) % int'(y)) == 0) begin
                    r = cnt_t'(int'(x) * i);
                end
            end
        end
        return r;
    endfunction

    function automatic cnt_t min2(input cnt_t x, input cnt_t y);
        return (x < y) ? x : y;
    endfunction

endpackage

// File: rtl/mbdiv_counter.sv
module mbdiv_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] div,
    output logic [W-1:0] cnt,
    output logic         last
);

    logic [W-1:0] cnt_q;

    assign last = en && (cnt_q == div - W'(1));
    assign cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            if (cnt_q == div - W'(1)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // R1: the count never leaves the range of the divide in force
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < div));

endmodule

// File: rtl/mbdiv_sync.sv
module mbdiv_sync
    import mbdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  cnt_t da,
    input  cnt_t dc,
    output logic raw_n,
    output logic last
);

    cnt_t frame;
    cnt_t lead;
    cnt_t pos;

    assign frame = lcm2(da, dc);
    assign lead  = min2(da, dc);

    mbdiv_counter #(.W(CW)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .div  (frame),
        .cnt  (pos),
        .last (last)
    );

    always_comb begin
        raw_n = !(pos >= frame - lead);
    end

    // R6: the marker is low on the final cycle of every frame
    p_low_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !raw_n);

endmodule

// File: rtl/mbdiv_freeze.sv
module mbdiv_freeze #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live,
    input  logic [W-1:0] req,
    output logic [W-1:0] out
);

    logic [W-1:0] frz_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                frz_q[i] <= 1'b0;
            end else if (!live[i]) begin
                frz_q[i] <= req[i];
            end
        end

        assign out[i] = live[i] & ~frz_q[i];

        // R10: freeze state may only move while the output is low
        p_frz_only_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
            live[i] |=> $stable(frz_q[i]));
    end

endmodule

// File: rtl/mbdiv_top.sv
module mbdiv_top
    import mbdiv_pkg::*;
#(
    parameter int NA = 4,
    parameter int NB = 4,
    parameter int NC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            sel_a,
    input  logic [1:0]            sel_b,
    input  logic [1:0]            sel_c,
    input  logic [1:0]            sel_fb,
    input  logic                  fb_x2,
    input  logic                  inv_c,
    input  logic [NA+NB+NC-1:0]   frz,
    output logic [NA-1:0]         qa,
    output logic [NB-1:0]         qb,
    output logic [NC-1:0]         qc,
    output logic                  qfb,
    output logic                  sync_n,
    output logic                  out_en
);

    localparam int NF    = NA + NB + NC;
    localparam int OFS_B = NA;
    localparam int OFS_C = NA + NB;
    localparam int INV_LO = NC / 2;

    mode_e st_q, st_d;
    cfg_t  req, cur_q;
    logic  run, align, load;

    cnt_t da, db, dc, df;
    cnt_t cnt_a, cnt_b, cnt_c, cnt_f;
    logic last_a, last_b, last_c, last_f, last_s;
    logic lvl_a, lvl_b, lvl_c, lvl_f, sync_raw;

    logic [NF-1:0] fz_live, fz_out;

    assign req = '{a: sel_a, b: sel_b, c: sel_c, f: sel_fb, x2: fb_x2};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  st_d = ST_RUN;
            ST_RUN:  st_d = (req != cur_q && !align) ? ST_PEND : ST_RUN;
            ST_PEND: st_d = (align || req == cur_q) ? ST_RUN : ST_PEND;
            default: st_d = ST_OFF;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        run  = 1'b0;
        load = 1'b0;
        unique case (st_q)
            ST_OFF:  begin run = 1'b0; load = 1'b1;  end
            ST_RUN:  begin run = 1'b1; load = align; end
            ST_PEND: begin run = 1'b1; load = align; end
            default: begin run = 1'b0; load = 1'b0;  end
        endcase
    end

    // selects in force: tracked during reset, swapped at alignment points
    always_ff @(posedge clk) begin
        if (load) begin
            cur_q <= req;
        end
    end

    assign da = div_a(cur_q.a);
    assign db = div_b(cur_q.b);
    assign dc = div_c(cur_q.c);
    assign df = div_f(cur_q.f, cur_q.x2);

    // ---------------- divider counters ----------------
    mbdiv_counter #(.W(CW)) u_cnt_a (
        .clk(clk), .rst_n(rst_n), .en(run), .div(da), .cnt(cnt_a), .last(last_a));
    mbdiv_counter #(.W(CW)) u_cnt_b (
        .clk(clk), .rst_n(rst_n), .en(run), .div(db), .cnt(cnt_b), .last(last_b));
    mbdiv_counter #(.W(CW)) u_cnt_c (
        .clk(clk), .rst_n(rst_n), .en(run), .div(dc), .cnt(cnt_c), .last(last_c));
    mbdiv_counter #(.W(CW)) u_cnt_f (
        .clk(clk), .rst_n(rst_n), .en(run), .div(df), .cnt(cnt_f), .last(last_f));

    mbdiv_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run),
        .da   (da),
        .dc   (dc),
        .raw_n(sync_raw),
        .last (last_s)
    );

    assign align = run && last_a && last_b && last_c && last_f && last_s;

    assign lvl_a = cnt_a < (da >> 1);
    assign lvl_b = cnt_b < (db >> 1);
    assign lvl_c = cnt_c < (dc >> 1);
    assign lvl_f = cnt_f < (df >> 1);

    // ---------------- freezable output vector ----------------
    for (genvar i = 0; i < NA; i++) begin : g_la
        assign fz_live[i] = run & lvl_a;
        assign qa[i]      = fz_out[i];
    end

    for (genvar i = 0; i < NB; i++) begin : g_lb
        assign fz_live[OFS_B+i] = run & lvl_b;
        assign qb[i]            = fz_out[OFS_B+i];
    end

    assign qc[0] = run & lvl_c;

    for (genvar i = 1; i < NC; i++) begin : g_lc
        if (i >= INV_LO) begin : g_inv
            assign fz_live[OFS_C+i-1] = run & (lvl_c ^ inv_c);
        end else begin : g_dir
            assign fz_live[OFS_C+i-1] = run & lvl_c;
        end
        assign qc[i] = fz_out[OFS_C+i-1];
    end

    assign fz_live[NF-1] = run & sync_raw;
    assign sync_n        = fz_out[NF-1];

    mbdiv_freeze #(.W(NF)) u_frz (
        .clk  (clk),
        .rst_n(rst_n),
        .live (fz_live),
        .req  (frz),
        .out  (fz_out)
    );

    assign qfb    = run & lvl_f;
    assign out_en = run;

    // ---------------- assertions ----------------
    // R9: the selects in force hold still except at alignment points
    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !align) |=> $stable(cur_q));

    // R6: the end of a marker frame is a bank A / bank C coincidence
    p_coincide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last_s) |=> (cnt_a == '0 && cnt_c == '0));

    // R8: disabled outputs stay low
    p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (qa == '0 && qb == '0 && qc == '0 && !qfb && !sync_n));

    // R5: every divider starts its count together
    p_start_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt_a == '0 && cnt_b == '0 && cnt_c == '0 && cnt_f == '0));

endmodule

// File: tb/mbdiv_top_test.sv
module mbdiv_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  sel_a, sel_b, sel_c, sel_fb;
    logic        fb_x2, inv_c;
    logic [11:0] frz;
    logic [3:0]  qa, qb, qc;
    logic        qfb, sync_n, out_en;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mbdiv_top uut (
        .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .sel_fb(sel_fb), .fb_x2(fb_x2), .inv_c(inv_c), .frz(frz),
        .qa(qa), .qb(qb), .qc(qc), .qfb(qfb), .sync_n(sync_n), .out_en(out_en)
    );

    // {sa, sb, sc, sf, x2, inv, na, nb, nc, nf}
    localparam logic [29:0] VEC [7] = '{
        {2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 5'd4,  5'd4,  5'd2, 5'd4},
        {2'd1, 2'd1, 2'd1, 2'd1, 1'b0, 1'b1, 5'd6,  5'd6,  5'd4, 5'd6},
        {2'd2, 2'd2, 2'd2, 2'd2, 1'b1, 1'b0, 5'd8,  5'd8,  5'd6, 5'd16},
        {2'd3, 2'd3, 2'd3, 2'd3, 1'b1, 1'b1, 5'd12, 5'd10, 5'd8, 5'd20},
        {2'd3, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 5'd12, 5'd4,  5'd4, 5'd4},
        {2'd1, 2'd3, 2'd3, 2'd2, 1'b0, 1'b1, 5'd6,  5'd10, 5'd8, 5'd8},
        {2'd0, 2'd2, 2'd2, 2'd1, 1'b1, 1'b0, 5'd4,  5'd8,  5'd6, 5'd12}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lcm(input int x, input int y);
        for (int i = 1; i <= y; i++) begin
            if ((x * i) % y == 0) return x * i;
        end
        return x * y;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check_cycle(input int t, input int na, input int nb,
                               input int nc, input int nf, input bit inv);
        bit   hc;
        int   l, m;
        logic [3:0] ea, eb, ec;
        ea = ((t % na) < na / 2) ? 4'hF : 4'h0;
        eb = ((t % nb) < nb / 2) ? 4'hF : 4'h0;
        hc = (t % nc) < nc / 2;
        ec = {hc ^ inv, hc ^ inv, hc, hc};
        l  = lcm(na, nc);
        m  = (na < nc) ? na : nc;
        chk("R1 qa", int'(qa), int'(ea));
        chk("R2 qb", int'(qb), int'(eb));
        chk("R3 R7 qc", int'(qc), int'(ec));
        chk("R4 qfb", int'(qfb), ((t % nf) < nf / 2) ? 1 : 0);
        chk("R6 sync_n", int'(sync_n), ((t % l) >= l - m) ? 0 : 1);
        chk("R8 out_en", int'(out_en), 1);
    endtask

    task automatic start(input logic [1:0] a, input logic [1:0] b,
                         input logic [1:0] c, input logic [1:0] f,
                         input logic x2, input logic inv);
        rst_n = 1'b0;
        sel_a = a; sel_b = b; sel_c = c; sel_fb = f; fb_x2 = x2; inv_c = inv;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sel_a = '0; sel_b = '0; sel_c = '0; sel_fb = '0;
        fb_x2 = 1'b0; inv_c = 1'b0; frz = '0;
        repeat (3) tick();

        // R8: reset state
        chk("R8 out_en in reset", int'(out_en), 0);
        chk("R8 outputs in reset", int'({qa, qb, qc, qfb, sync_n}), 0);

        // table walk: R1..R7
        foreach (VEC[v]) begin
            start(VEC[v][29:28], VEC[v][27:26], VEC[v][25:24], VEC[v][23:22],
                  VEC[v][21], VEC[v][20]);
            for (int k = 1; k <= 60; k++) begin
                tick();
                if (k == 1) begin
                    chk("R5 aligned first edge", int'({qa[0], qb[0], qc[0], qfb}), 15);
                end
                check_cycle(k - 1, int'(VEC[v][19:15]), int'(VEC[v][14:10]),
                            int'(VEC[v][9:5]), int'(VEC[v][4:0]), VEC[v][20]);
            end
        end

        // R9: a mid-frame select change waits for the alignment point
        start(2'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0);
        tick(); tick();
        sel_a = 2'd0;
        tick(); tick(); tick();
        chk("R9 old ratio kept (k5)", int'(qa[0]), 0);
        tick(); tick(); tick();
        chk("R9 old ratio kept (k8)", int'(qa[0]), 0);
        tick();
        chk("R9 new ratio start (k9)", int'(qa[0]), 1);
        tick(); tick();
        chk("R9 new ratio low (k11)", int'(qa[0]), 0);
        tick(); tick();
        chk("R9 new ratio high (k13)", int'(qa[0]), 1);

        // R10: freeze and release without runt pulses
        start(2'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0);
        tick(); tick();
        frz[1] = 1'b1;
        tick(); tick();
        chk("R10 pulse in progress completes", int'(qa[1]), 1);
        repeat (5) tick();
        chk("R10 frozen output low", int'(qa[1]), 0);
        chk("R10 neighbour still runs", int'(qa[0]), 1);
        frz[1] = 1'b0;
        tick();
        chk("R10 no runt after release", int'(qa[1]), 0);
        tick(); tick();
        chk("R10 still parked mid-high", int'(qa[1]), 0);
        repeat (5) tick();
        chk("R10 whole pulse resumes", int'(qa[1]), 1);

        // R8: asynchronous reset while running
        start(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0);
        repeat (4) tick();
        rst_n = 1'b0;
        #1;
        chk("R8 async disable", int'(out_en), 0);
        chk("R8 async outputs low", int'({qa, qb, qc, qfb, sync_n}), 0);
        rst_n = 1'b1;
        tick();
        chk("R8 enabled after release", int'(out_en), 1);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule